// File: doc/BRIEF.md
# Dual-Clock FIFO with Half-Full and Programmable Almost-Full Flags

This block is a first-in first-out buffer of 18-bit words. Its write side and its read side run on two unrelated clocks. It drives two active-low status outputs. The half-full flag reports that more than half of the usable depth is occupied. The almost-full flag reports that the fill level has come within a programmable offset of the usable depth. Each flag is driven active by the write clock and released by the read clock. A producer can therefore throttle itself as soon as its own write crosses a threshold, and the flag releases as soon as the consumer drains below it.

Reads work in one of two modes, chosen while reset is held low. In standard mode a sampled read enable moves the head word onto the data output on that read edge. In look-ahead mode the head word is already on the output before it is requested, and the read enable retires it. The output register then acts as one extra storage slot, so the usable depth grows by one and both thresholds move with it. The almost-full offset is captured from an input during reset when a load strobe is high; otherwise a default of 7 applies. The mode and the offset stay fixed until the next reset. The pointers cross between the clocks in Gray code through two-flop synchronizers.

Top module: `dcfifo_flags`

## Requirements
- R1: While `rst_n` is low, the FIFO empties, `rdata` becomes 0 and both flags go high. The mode (`cfg_fwft`) and the offset inputs are captured at that time; changing them after reset has no effect.
- R2: In standard mode (`cfg_fwft`=0) the FIFO holds 256 words, returned in write order. A write while 256 words are held is dropped and does not corrupt stored data.
- R3: In look-ahead mode (`cfg_fwft`=1) the FIFO holds 257 words. The head word appears on `rdata` without a read request and stays there until a read retires it.
- R4: In standard mode, `hf_n` is low once the count is 129 or more and high at 128 or less.
- R5: In look-ahead mode, `hf_n` is low once the count is 130 or more and high at 129 or less.
- R6: `af_n` is low once the count reaches D−m and high at D−m−1 or less, where D is 256 in standard mode and 257 in look-ahead mode.
- R7: m is `cfg_off` when `cfg_off_load` is high during reset, and 7 otherwise.
- R8: A flag only goes low as a result of a write-clock edge and only goes high as a result of a read-clock edge.
- R9: A read while the FIFO is empty is ignored: `rdata` and the stored contents are unchanged.
- R10: In standard mode, `rdata` changes only on a read-clock edge that samples `ren` high with data available, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst_n | input | 1 | Active-low reset, held over several edges of both clocks |
| cfg_fwft | input | 1 | Read mode captured in reset: 1 = look-ahead, 0 = standard |
| cfg_off_load | input | 1 | During reset, 1 takes the offset from `cfg_off` |
| cfg_off | input | 8 | Almost-full offset m |
| wen | input | 1 | Write request, sampled on `wclk` |
| wdata | input | 18 | Write word |
| ren | input | 1 | Read request, sampled on `rclk` |
| rdata | output | 18 | Read word |
| af_n | output | 1 | Almost-full flag, active low |
| hf_n | output | 1 | Half-full flag, active low |

## Verification
On every edge, the embedded properties check four things:
- the split flag logic makes a flag active only from the write side and inactive only from the read side;
- neither domain's view of the memory count leaves its legal range;
- standard-mode data holds while no read is requested;
- a presented look-ahead word stays put until it is retired.

The exact threshold counts in both modes, the captured and default offsets, the dropped overfill writes and the order of returned data can only be shown by the bench's scenarios. The bench compares against a queue model after the synchronizers have settled.

// File: rtl/fifo_flag_pkg.sv
// Shared types for the dual-clock flag FIFO.
// Assumes nothing beyond standard SystemVerilog packages.
package fifo_flag_pkg;

    // Read behaviour captured during reset
    typedef enum logic {
        MODE_STD  = 1'b0,
        MODE_FWFT = 1'b1
    } rd_mode_e;

    // Number of flags produced by the split set/clear logic
    localparam int NUM_FLAGS = 2;
    localparam int FLAG_HF   = 0;
    localparam int FLAG_AF   = 1;

endpackage

// File: rtl/fifo_xing.sv
// Carries a binary pointer plus a few level bits from one clock to another.
// The pointer is Gray-registered in the source domain, passed through two
// destination flops and converted back to binary.
// Assumes the pointer moves by at most one per source edge.
module fifo_xing #(
    parameter int PW = 9,
    parameter int XW = 2
) (
    input  logic          sclk,
    input  logic          dclk,
    input  logic          rst_n,
    input  logic [PW-1:0] bin_in,
    input  logic [XW-1:0] ext_in,
    output logic [PW-1:0] bin_out,
    output logic [XW-1:0] ext_out
);
    logic [PW+XW-1:0] src_q, meta_q, sync_q;
    logic [PW-1:0]    gray_s;

    // Source stage: register the Gray code and the side bits together
    always_ff @(posedge sclk) begin
        if (!rst_n) src_q <= '0;
        else        src_q <= {bin_in ^ (bin_in >> 1), ext_in};
    end

    // Destination stage: two flops against metastability
    always_ff @(posedge dclk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= src_q;
            sync_q <= meta_q;
        end
    end

    assign gray_s  = sync_q[PW+XW-1:XW];
    assign ext_out = sync_q[XW-1:0];

    // Gray back to binary, most significant bit first
    always_comb begin
        bin_out[PW-1] = gray_s[PW-1];
        for (int i = PW - 2; i >= 0; i--) begin
            bin_out[i] = bin_out[i+1] ^ gray_s[i];
        end
    end
endmodule

// File: rtl/fifo_wr_side.sv
// Write-domain control: captures mode and offset in reset, advances the
// write pointer, refuses writes while the memory is full and forms the
// post-edge word count used to set the flags.
// Assumes rbin_s and ov_s are already synchronized to wclk.
module fifo_wr_side
    import fifo_flag_pkg::*;
#(
    parameter int AW         = 8,
    parameter int AF_DEFAULT = 7
) (
    input  logic          wclk,
    input  logic          rst_n,
    input  logic          cfg_fwft,
    input  logic          cfg_off_load,
    input  logic [AW-1:0] cfg_off,
    input  logic          wen,
    input  logic [AW:0]   rbin_s,
    input  logic          ov_s,
    output logic [AW:0]   wbin,
    output logic          we,
    output rd_mode_e      mode,
    output logic [AW-1:0] af_off,
    output logic [AW+1:0] cnt_nxt
);
    logic [AW:0] mem_cnt, wbin_nxt;
    logic        full;

    assign mem_cnt  = wbin - rbin_s;
    assign full     = mem_cnt[AW];
    assign we       = wen & ~full;
    assign wbin_nxt = wbin + {{AW{1'b0}}, we};
    assign cnt_nxt  = {1'b0, wbin_nxt - rbin_s}
                    + {{(AW+1){1'b0}}, ov_s & (mode == MODE_FWFT)};

    // Pointer update; configuration capture while reset is held
    always_ff @(posedge wclk) begin
        if (!rst_n) begin
            wbin   <= '0;
            mode   <= rd_mode_e'(cfg_fwft);
            af_off <= cfg_off_load ? cfg_off : AW'(AF_DEFAULT);
        end else begin
            wbin   <= wbin_nxt;
        end
    end

    AST_WCOUNT_BOUND: assert property (@(posedge wclk) disable iff (!rst_n)
        mem_cnt <= (AW+1)'(1 << AW)) else $error("write view over capacity"); // R2
endmodule

// File: rtl/fifo_rd_side.sv
// Read-domain control: standard reads or look-ahead with a valid output
// register, read pointer, data register and the post-edge word count
// used to clear the flags.
// Assumes wbin_s is synchronized to rclk and mem_q is mem[rbin].
module fifo_rd_side
    import fifo_flag_pkg::*;
#(
    parameter int AW         = 8,
    parameter int DW         = 18,
    parameter int AF_DEFAULT = 7
) (
    input  logic          rclk,
    input  logic          rst_n,
    input  logic          cfg_fwft,
    input  logic          cfg_off_load,
    input  logic [AW-1:0] cfg_off,
    input  logic          ren,
    input  logic [AW:0]   wbin_s,
    input  logic [DW-1:0] mem_q,
    output logic [AW:0]   rbin,
    output logic          ov,
    output logic [DW-1:0] rdata,
    output rd_mode_e      mode,
    output logic [AW-1:0] af_off,
    output logic [AW+1:0] cnt_nxt
);
    logic [AW:0] mem_cnt, rbin_nxt;
    logic        mem_empty, pop, ov_nxt;

    assign mem_cnt   = wbin_s - rbin;
    assign mem_empty = (mem_cnt == '0);

    // Decide whether a word leaves memory this edge, per read mode
    always_comb begin
        if (mode == MODE_FWFT) begin
            pop    = ~mem_empty & (~ov | ren);
            ov_nxt = pop | (ov & ~ren);
        end else begin
            pop    = ren & ~mem_empty;
            ov_nxt = 1'b0;
        end
    end

    assign rbin_nxt = rbin + {{AW{1'b0}}, pop};
    assign cnt_nxt  = {1'b0, wbin_s - rbin_nxt} + {{(AW+1){1'b0}}, ov_nxt};

    // Pointer, output register and configuration capture
    always_ff @(posedge rclk) begin
        if (!rst_n) begin
            rbin   <= '0;
            ov     <= 1'b0;
            rdata  <= '0;
            mode   <= rd_mode_e'(cfg_fwft);
            af_off <= cfg_off_load ? cfg_off : AW'(AF_DEFAULT);
        end else begin
            rbin <= rbin_nxt;
            ov   <= ov_nxt;
            if (pop) rdata <= mem_q;
        end
    end

    AST_RCOUNT_BOUND: assert property (@(posedge rclk) disable iff (!rst_n)
        mem_cnt <= (AW+1)'(1 << AW)) else $error("read past write pointer"); // R9
    AST_STD_HOLD: assert property (@(posedge rclk) disable iff (!rst_n)
        (mode == MODE_STD && !ren) |=> $stable(rdata)) else $error("std data moved"); // R10
    AST_FWFT_KEEP: assert property (@(posedge rclk) disable iff (!rst_n)
        (mode == MODE_FWFT && ov && !ren) |=> (ov && $stable(rdata))) else $error("head lost"); // R3
endmodule

// File: rtl/fifo_flag_pair.sv
// One status flag split across the clocks: a write-domain toggle raises
// it and a read-domain toggle lowers it; the flag is their XOR, inverted.
// Assumes tr_s and tw_s arrive through the same synchronizers as the
// pointers, so that the counts and toggles agree.
module fifo_flag_pair #(
    parameter int CW = 10
) (
    input  logic          wclk,
    input  logic          rclk,
    input  logic          rst_n,
    input  logic [CW-1:0] cnt_w,
    input  logic [CW-1:0] thr_w,
    input  logic          tr_s,
    input  logic [CW-1:0] cnt_r,
    input  logic [CW-1:0] thr_r,
    input  logic          tw_s,
    output logic          tw,
    output logic          tr,
    output logic          flag_n
);
    // Write side: make the flag active when the count reaches threshold
    always_ff @(posedge wclk) begin
        if (!rst_n)                            tw <= 1'b0;
        else if (tw == tr_s && cnt_w >= thr_w) tw <= ~tw;
    end

    // Read side: make the flag inactive when the count drops below
    always_ff @(posedge rclk) begin
        if (!rst_n)                           tr <= 1'b0;
        else if (tw_s != tr && cnt_r < thr_r) tr <= ~tr;
    end

    assign flag_n = ~(tw ^ tr);

    AST_SET_ON_WCLK: assert property (@(posedge wclk) disable iff (!rst_n)
        (tw != $past(tw)) |-> (tw ^ tr)) else $error("write edge released flag"); // R8
    AST_CLR_ON_RCLK: assert property (@(posedge rclk) disable iff (!rst_n)
        (tr != $past(tr)) |-> !(tw ^ tr)) else $error("read edge raised flag"); // R8
endmodule

// File: rtl/dcfifo_flags.sv
// Top: dual-clock FIFO with storage, pointer crossings and the two flags.
// The thresholds come from the captured mode and offset in each domain.
// Assumes rst_n is held low across several edges of both clocks.
module dcfifo_flags
    import fifo_flag_pkg::*;
#(
    parameter int AW         = 8,
    parameter int DW         = 18,
    parameter int AF_DEFAULT = 7
) (
    input  logic          wclk,
    input  logic          rclk,
    input  logic          rst_n,
    input  logic          cfg_fwft,
    input  logic          cfg_off_load,
    input  logic [AW-1:0] cfg_off,
    input  logic          wen,
    input  logic [DW-1:0] wdata,
    input  logic          ren,
    output logic [DW-1:0] rdata,
    output logic          af_n,
    output logic          hf_n
);
    localparam int PW    = AW + 1;
    localparam int CW    = AW + 2;
    localparam int DEPTH = 1 << AW;
    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
    localparam logic [CW-1:0] HALF_C  = CW'(DEPTH / 2);

    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] mem_q;
    logic [PW-1:0] wbin, rbin, wbin_s, rbin_s;
    logic          we, ov, ov_s;
    rd_mode_e      mode_w, mode_r;
    logic [AW-1:0] off_w, off_r;
    logic [CW-1:0] cnt_w, cnt_r;
    logic [CW-1:0] thr_w [NUM_FLAGS];
    logic [CW-1:0] thr_r [NUM_FLAGS];
    logic [NUM_FLAGS-1:0] tw, tr, tw_s, tr_s, fl_n;

    // Storage: written on wclk, read address from the read pointer
    always_ff @(posedge wclk) begin
        if (we) mem[wbin[AW-1:0]] <= wdata;
    end
    assign mem_q = mem[rbin[AW-1:0]];

    fifo_wr_side #(.AW(AW), .AF_DEFAULT(AF_DEFAULT)) u_wr (
        .wclk(wclk), .rst_n(rst_n), .cfg_fwft(cfg_fwft),
        .cfg_off_load(cfg_off_load), .cfg_off(cfg_off), .wen(wen),
        .rbin_s(rbin_s), .ov_s(ov_s), .wbin(wbin), .we(we),
        .mode(mode_w), .af_off(off_w), .cnt_nxt(cnt_w));

    fifo_rd_side #(.AW(AW), .DW(DW), .AF_DEFAULT(AF_DEFAULT)) u_rd (
        .rclk(rclk), .rst_n(rst_n), .cfg_fwft(cfg_fwft),
        .cfg_off_load(cfg_off_load), .cfg_off(cfg_off), .ren(ren),
        .wbin_s(wbin_s), .mem_q(mem_q), .rbin(rbin), .ov(ov),
        .rdata(rdata), .mode(mode_r), .af_off(off_r), .cnt_nxt(cnt_r));

    fifo_xing #(.PW(PW), .XW(NUM_FLAGS)) u_w2r (
        .sclk(wclk), .dclk(rclk), .rst_n(rst_n),
        .bin_in(wbin), .ext_in(tw), .bin_out(wbin_s), .ext_out(tw_s));

    fifo_xing #(.PW(PW), .XW(NUM_FLAGS + 1)) u_r2w (
        .sclk(rclk), .dclk(wclk), .rst_n(rst_n),
        .bin_in(rbin), .ext_in({ov, tr}), .bin_out(rbin_s), .ext_out({ov_s, tr_s}));

    // Thresholds per domain: look-ahead adds one slot to the depth
    always_comb begin
        thr_w[FLAG_HF] = (mode_w == MODE_FWFT) ? HALF_C + CW'(2) : HALF_C + CW'(1);
        thr_r[FLAG_HF] = (mode_r == MODE_FWFT) ? HALF_C + CW'(2) : HALF_C + CW'(1);
        thr_w[FLAG_AF] = DEPTH_C + CW'(mode_w == MODE_FWFT) - {2'b00, off_w};
        thr_r[FLAG_AF] = DEPTH_C + CW'(mode_r == MODE_FWFT) - {2'b00, off_r};
    end

    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
        fifo_flag_pair #(.CW(CW)) u_flag (
            .wclk(wclk), .rclk(rclk), .rst_n(rst_n),
            .cnt_w(cnt_w), .thr_w(thr_w[g]), .tr_s(tr_s[g]),
            .cnt_r(cnt_r), .thr_r(thr_r[g]), .tw_s(tw_s[g]),
            .tw(tw[g]), .tr(tr[g]), .flag_n(fl_n[g]));
    end

    assign hf_n = fl_n[FLAG_HF];
    assign af_n = fl_n[FLAG_AF];
endmodule

// File: tb/dcfifo_flags_tb_top.sv
`timescale 1ns/1ps
module dcfifo_flags_tb_top;
    logic        wclk = 0, rclk = 0, rst_n = 0;
    logic        cfg_fwft = 0, cfg_off_load = 0;
    logic [7:0]  cfg_off = 0;
    logic        wen = 0, ren = 0;
    logic [17:0] wdata = 0;
    logic [17:0] rdata;
    logic        af_n, hf_n;

    int unsigned compared = 0, mismatched = 0;
    int          q[$];
    int          depth = 256, m_off = 7, hf_thr = 129;
    bit          fwft = 0, done = 0;
    int          seed = 100;
    int          prev = 0;

    always #2.5 wclk = ~wclk;
    always #3.5 rclk = ~rclk;

    dcfifo_flags dut_i (
        .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .cfg_fwft(cfg_fwft),
        .cfg_off_load(cfg_off_load), .cfg_off(cfg_off), .wen(wen),
        .wdata(wdata), .ren(ren), .rdata(rdata), .af_n(af_n), .hf_n(hf_n));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic settle();
        repeat (12) @(negedge rclk);
    endtask

    task automatic check_flags(input string req);
        int n = q.size();
        check(hf_n == !(n >= hf_thr), {req, " hf_n"}, hf_n, !(n >= hf_thr));
        check(af_n == !(n >= depth - m_off), {req, " af_n"}, af_n, !(n >= depth - m_off));
    endtask

    task automatic do_reset(input bit mode, input bit load, input int off);
        cfg_fwft = mode; cfg_off_load = load; cfg_off = 8'(off);
        wen = 0; ren = 0; rst_n = 0;
        repeat (6) @(negedge rclk);
        rst_n = 1;
        fwft = mode; depth = mode ? 257 : 256; hf_thr = mode ? 130 : 129;
        m_off = load ? off : 7;
        q.delete(); prev = 0;
        cfg_fwft = ~mode; cfg_off_load = 1; cfg_off = 8'd3; // R1: later values must not matter
    endtask

    task automatic wr(input int n, input bit each);
        for (int i = 0; i < n; i++) begin
            @(negedge wclk); wen = 1; wdata = 18'(seed);
            @(negedge wclk); wen = 0;
            if (q.size() < depth) q.push_back(seed);
            seed++;
            if (each) settle();
        end
    endtask

    task automatic rd(input int n);
        for (int i = 0; i < n; i++) begin
            if (fwft) begin
                @(negedge rclk);
                if (q.size() > 0) check(rdata == 18'(q[0]), "R3 head word", rdata, q[0]);
                ren = 1; @(negedge rclk); ren = 0;
                if (q.size() > 0) void'(q.pop_front());
            end else begin
                @(negedge rclk); ren = 1; @(negedge rclk); ren = 0;
                if (q.size() > 0) begin
                    prev = q.pop_front();
                    check(rdata == 18'(prev), "R10 R2 read order", rdata, prev);
                end else begin
                    check(rdata == 18'(prev), "R9 empty read", rdata, prev);
                end
            end
        end
    endtask

    initial begin
        #1000000;
        if (!done) begin
            mismatched++; compared++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        // Standard mode, default offset 7
        do_reset(0, 0, 50);
        @(negedge rclk);
        check(rdata == 0, "R1 rdata", rdata, 0);
        check_flags("R1");
        wr(128, 0); settle(); check_flags("R4 at 128");
        wr(1, 1); check_flags("R4 at 129");
        rd(1); settle(); check_flags("R4 back to 128");
        wr(248 - q.size(), 0); settle(); check_flags("R7 R6 at 248");
        wr(1, 1); check_flags("R7 R6 at 249");
        wr(256 - q.size(), 1);
        wr(2, 1); check_flags("R2 overfill");
        check(q.size() == 256, "R2 model depth", q.size(), 256);
        for (int i = 0; i < 8; i++) begin rd(1); settle(); check_flags("R6 R4 drain"); end
        rd(q.size()); settle(); check_flags("R2 empty");
        rd(3); settle(); check_flags("R9");
        wr(2, 0); settle(); rd(1);
        repeat (5) @(negedge rclk);
        check(rdata == 18'(prev), "R10 hold", rdata, prev);
        rd(1);

        // Look-ahead mode, loaded offset 20
        do_reset(1, 1, 20);
        settle(); check_flags("R1 fwft");
        wr(1, 1);
        check(rdata == 18'(q[0]), "R3 presented", rdata, q[0]);
        wr(129 - q.size(), 0); settle(); check_flags("R5 at 129");
        wr(1, 1); check_flags("R5 at 130");
        rd(1); settle(); check_flags("R5 back to 129");
        wr(236 - q.size(), 0); settle(); check_flags("R6 R1 at 236");
        wr(1, 1); check_flags("R6 at 237");
        wr(257 - q.size(), 1);
        wr(1, 1); check_flags("R3 overfill");
        check(q.size() == 257, "R3 model depth", q.size(), 257);
        rd(1); settle(); check_flags("R6 R5 at 256");
        rd(q.size()); settle(); check_flags("R3 drained");
        rd(2); settle();
        wr(1, 1);
        check(rdata == 18'(q[0]), "R9 R3 after empty read", rdata, q[0]);
        rd(1);

        // Standard mode, loaded offset 0
        do_reset(0, 1, 0);
        wr(255, 0); settle(); check_flags("R7 R6 at 255");
        wr(1, 1); check_flags("R7 R6 at 256");
        rd(256); settle(); check_flags("R2 final");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule